// File: doc/BRIEF.md
# SMBus Event Router

This block takes the event sources of an SMBus controller and turns them into three requests for the rest of the chip: a level interrupt request, a system-management interrupt (SMI) with separate host-side and slave-side outputs, and a single-cycle wake request. The sources are host transaction status events (completion and error causes), an active-low alert pin, two slave command writes (a wake/SMI command and a link-slave SMI command), and received host-notify messages.

Each source sets a sticky status bit that software clears by writing 1 to it. The interrupt and SMI outputs are levels formed from those status bits and the routing enables. A single SMI-select bit sends every interrupt-eligible source to SMI in place of the interrupt line. The routing rules are additive: when one event matches several rules, every matching result fires in the same cycle. A sleep input decides whether a slave wake/SMI command wakes the system or raises an SMI. A fully-on input gates the link-slave command.

Top module: `smb_evt_router`

## Requirements
- R1: A pulse on `host_evt[i]` sets `host_sts[i]` after that clock edge. Status bits stay set until a clear strobe of 1 reaches that same bit. When a set and a clear land in the same cycle, the set wins.
- R2: While any of `host_sts[HOST_EVT_W-1:0]` is set, `irq` is high when `cfg_int_en`=1 and `cfg_smi_sel`=0.
- R3: While any host event status bit is set, `host_smi` is high when `cfg_int_en`=1 and `cfg_smi_sel`=1. With `cfg_int_en`=0, those bits drive neither `irq` nor `host_smi`, and `irq` is never high while `cfg_smi_sel`=1.
- R4: `alert_n` passes through two synchronizer flops. Its falling edge sets `host_sts[HOST_EVT_W]` (the alert bit) whatever the enables are. That bit is visible three clock edges after the low level is first sampled, and holding the pin low sets it only once.
- R5: A set alert bit drives `irq` when `cfg_int_en`=1, `cfg_smi_sel`=0 and `cfg_alert_dis`=0. It drives `slave_smi` when `cfg_smi_sel`=1 and `cfg_alert_dis`=0. An alert falling edge pulses `wake` when `sys_asleep`=1 and `cfg_alert_dis`=0. `cfg_alert_dis`=1 blocks all three results, but the alert status bit is still recorded.
- R6: A `slv_wake_cmd` pulse while `sys_asleep`=1 pulses `wake` and leaves `slv_smi_sts` clear. While `sys_asleep`=0 it sets `slv_smi_sts`, and that bit drives `slave_smi`.
- R7: A `slv_link_cmd` pulse sets `slv_smi_sts` only when `sys_full_on`=1, whatever the enables are. Otherwise it has no effect.
- R8: A `notify_evt` pulse always sets `notify_sts`. It pulses `wake` when `cfg_ntfy_wake_en`=1 and `sys_asleep`=1, whatever the other enables are.
- R9: A set `notify_sts` with `cfg_ntfy_int_en`=1 drives `irq` when `cfg_smi_sel`=0 and `slave_smi` when `cfg_smi_sel`=1. With both notify enables at 0 it drives no output.
- R10: `wake` is high for exactly one cycle per triggering event, in the cycle after the event is sampled, and only if `sys_asleep` was high when the event was sampled.
- R11: When one event matches several routing rules, all the matching results occur together (for example `wake` and `irq` from the same host-notify).
- R12: While `rst_n`=0 and after reset, all status bits are 0, `wake` is 0, and `irq`, `host_smi` and `slave_smi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_evt | input | HOST_EVT_W | One-cycle host transaction status event pulses |
| alert_n | input | 1 | Asynchronous active-low alert pin |
| slv_wake_cmd | input | 1 | Pulse: slave write of the wake/SMI command |
| slv_link_cmd | input | 1 | Pulse: slave write of the link-slave SMI command |
| notify_evt | input | 1 | Pulse: host-notify message received |
| cfg_int_en | input | 1 | Interrupt enable for the host and alert sources |
| cfg_smi_sel | input | 1 | 1 redirects interrupt-eligible sources to SMI |
| cfg_alert_dis | input | 1 | Blocks the alert from interrupt, SMI and wake |
| cfg_ntfy_int_en | input | 1 | Host-notify interrupt/SMI enable |
| cfg_ntfy_wake_en | input | 1 | Host-notify wake enable |
| sys_asleep | input | 1 | System is in a sleep state |
| sys_full_on | input | 1 | System is in the fully-on state |
| host_clr | input | HOST_EVT_W+1 | Write-1-to-clear strobes for the host and alert status bits |
| slv_smi_clr | input | 1 | Write-1-to-clear strobe for the slave SMI status bit |
| notify_clr | input | 1 | Write-1-to-clear strobe for the host-notify status bit |
| host_sts | output | HOST_EVT_W+1 | Host status: event bits, with the alert bit on top |
| slv_smi_sts | output | 1 | Slave SMI status from the slave commands |
| notify_sts | output | 1 | Host-notify status |
| irq | output | 1 | Level interrupt request |
| host_smi | output | 1 | Host-side SMI level |
| slave_smi | output | 1 | Slave-side SMI level |
| wake | output | 1 | One-cycle wake request |

## Verification
The assertions check on every cycle that status bits never drop without a clear strobe, and that `irq` stays low under SMI-select. They also check that `host_smi` needs both the interrupt enable and SMI-select, that every wake pulse follows a cycle with the sleep input high, and that the alert and slave SMI status bits rise only after a matching cause at the ports. The directed scenarios are needed to show the positive routing: the three-edge alert latency and the single set per held-low alert, the suppression by the alert disable bit, the sleep-dependent split of the slave command, and the additive case where one host-notify yields both wake and interrupt.

// File: rtl/smb_evt_pkg.sv
// Package: shared configuration type for the SMBus event router.
// Assumes: all enables are quasi-static register bits already in the clock domain.
package smb_evt_pkg;

    typedef struct packed {
        logic int_en;       // interrupt enable, host and alert sources
        logic smi_sel;      // redirect interrupt-eligible sources to SMI
        logic alert_dis;    // block alert from every output
        logic ntfy_int_en;  // host-notify interrupt/SMI enable
        logic ntfy_wake_en; // host-notify wake enable
    } route_cfg_t;

endpackage

// File: rtl/smb_alert_sync.sv
// Module: smb_alert_sync
// Brings the asynchronous active-low alert pin into the clock domain through
// STAGES flops and flags one cycle for each high-to-low transition.
// Assumes: the pin idles high; the flops reset to 1 so that reset creates no edge.
module smb_alert_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_n};
        end
    end

    // Hold the last synchronized level to detect the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // High for one cycle when the synchronized level has just gone low.
    assign fall_o = prev_q & ~sync_q[LAST];

endmodule

// File: rtl/smb_sts_bank.sv
// Module: smb_sts_bank
// A row of sticky status bits. A set pulse latches a bit, and a clear strobe of 1
// releases it. When both arrive in the same cycle the set wins, so no event is lost.
// Assumes: set and clear inputs are single-cycle pulses in the clock domain.
module smb_sts_bank #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] sts_o
);

    logic [WIDTH-1:0] sts_q;

    // Latch new events, drop cleared bits, and let a set beat a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_i) | set_i;
        end
    end

    assign sts_o = sts_q;

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_q & ~clr_i)) |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0))
        else $error("status bit dropped without a clear");

endmodule

// File: rtl/smb_evt_route.sv
// Module: smb_evt_route
// Combines the latched status with the routing enables into the interrupt and
// SMI levels. It also registers the one-cycle wake request from the raw event pulses.
// Every rule is evaluated on its own and the results are ORed (additive routing).
// Assumes: status inputs come from the sticky bank and event inputs are one-cycle pulses.
module smb_evt_route
    import smb_evt_pkg::*;
#(
    parameter int HOST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  route_cfg_t        cfg,
    input  logic              asleep,
    input  logic [HOST_W-1:0] host_sts,
    input  logic              alert_sts,
    input  logic              slv_sts,
    input  logic              ntfy_sts,
    input  logic              wake_cmd,
    input  logic              ntfy_evt,
    input  logic              alert_fall,
    output logic              irq_o,
    output logic              host_smi_o,
    output logic              slave_smi_o,
    output logic              wake_o
);

    logic host_any;
    logic alert_live;
    logic ntfy_live;
    logic wake_d;
    logic wake_q;

    // Per-source qualifiers shared by the interrupt and SMI paths.
    always_comb begin
        host_any   = |host_sts;
        alert_live = alert_sts & ~cfg.alert_dis;
        ntfy_live  = ntfy_sts & cfg.ntfy_int_en;
    end

    // Interrupt and SMI levels: the select bit moves each source from one to the other.
    always_comb begin
        irq_o       = ~cfg.smi_sel & ((host_any & cfg.int_en)
                                    | (alert_live & cfg.int_en)
                                    | ntfy_live);
        host_smi_o  = cfg.smi_sel & cfg.int_en & host_any;
        slave_smi_o = slv_sts | (cfg.smi_sel & (alert_live | ntfy_live));
    end

    // Wake request from any wake-capable event seen while asleep.
    always_comb begin
        wake_d = asleep & (wake_cmd
                         | (ntfy_evt & cfg.ntfy_wake_en)
                         | (alert_fall & ~cfg.alert_dis));
    end

    // Register the wake request as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= wake_d;
        end
    end

    assign wake_o = wake_q;

    // R10
    wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(asleep))
        else $error("wake without sleep");

    // R3
    smi_sel_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.smi_sel |-> !irq_o)
        else $error("interrupt raised under SMI select");

    // R3
    host_smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_smi_o |-> (cfg.int_en && cfg.smi_sel))
        else $error("host SMI without enables");

endmodule

// File: rtl/smb_evt_router.sv
// Module: smb_evt_router (top)
// Routes SMBus controller events to interrupt, host/slave SMI and wake outputs.
// It instantiates the alert synchronizer, one sticky status bank for all sources
// and the routing logic.
// Assumes: event inputs are one-cycle pulses; the clear strobes are write-1 pulses;
// alert_n may change at any time.
module smb_evt_router
    import smb_evt_pkg::*;
#(
    parameter int HOST_EVT_W  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HOST_EVT_W-1:0] host_evt,
    input  logic                  alert_n,
    input  logic                  slv_wake_cmd,
    input  logic                  slv_link_cmd,
    input  logic                  notify_evt,
    input  logic                  cfg_int_en,
    input  logic                  cfg_smi_sel,
    input  logic                  cfg_alert_dis,
    input  logic                  cfg_ntfy_int_en,
    input  logic                  cfg_ntfy_wake_en,
    input  logic                  sys_asleep,
    input  logic                  sys_full_on,
    input  logic [HOST_EVT_W:0]   host_clr,
    input  logic                  slv_smi_clr,
    input  logic                  notify_clr,
    output logic [HOST_EVT_W:0]   host_sts,
    output logic                  slv_smi_sts,
    output logic                  notify_sts,
    output logic                  irq,
    output logic                  host_smi,
    output logic                  slave_smi,
    output logic                  wake
);

    localparam int ALERT_IDX = HOST_EVT_W;
    localparam int SLV_IDX   = HOST_EVT_W + 1;
    localparam int NTFY_IDX  = HOST_EVT_W + 2;
    localparam int STS_W     = HOST_EVT_W + 3;

    route_cfg_t       cfg;
    logic             alert_fall;
    logic             slv_set;
    logic [STS_W-1:0] sts_set;
    logic [STS_W-1:0] sts_clr;
    logic [STS_W-1:0] sts_all;

    // Gather the enable pins into the shared configuration struct.
    always_comb begin
        cfg.int_en       = cfg_int_en;
        cfg.smi_sel      = cfg_smi_sel;
        cfg.alert_dis    = cfg_alert_dis;
        cfg.ntfy_int_en  = cfg_ntfy_int_en;
        cfg.ntfy_wake_en = cfg_ntfy_wake_en;
    end

    smb_alert_sync #(
        .STAGES (SYNC_STAGES)
    ) u_alert_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (alert_n),
        .fall_o (alert_fall)
    );

    // Slave SMI cause: wake/SMI command while awake, or link command while fully on.
    always_comb begin
        slv_set = (slv_wake_cmd & ~sys_asleep) | (slv_link_cmd & sys_full_on);
    end

    // Pack the set and clear vectors in status-bank order.
    always_comb begin
        sts_set = {notify_evt, slv_set, alert_fall, host_evt};
        sts_clr = {notify_clr, slv_smi_clr, host_clr};
    end

    smb_sts_bank #(
        .WIDTH (STS_W)
    ) u_sts_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sts_set),
        .clr_i (sts_clr),
        .sts_o (sts_all)
    );

    assign host_sts    = sts_all[ALERT_IDX:0];
    assign slv_smi_sts = sts_all[SLV_IDX];
    assign notify_sts  = sts_all[NTFY_IDX];

    smb_evt_route #(
        .HOST_W (HOST_EVT_W)
    ) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .asleep      (sys_asleep),
        .host_sts    (sts_all[HOST_EVT_W-1:0]),
        .alert_sts   (sts_all[ALERT_IDX]),
        .slv_sts     (sts_all[SLV_IDX]),
        .ntfy_sts    (sts_all[NTFY_IDX]),
        .wake_cmd    (slv_wake_cmd),
        .ntfy_evt    (notify_evt),
        .alert_fall  (alert_fall),
        .irq_o       (irq),
        .host_smi_o  (host_smi),
        .slave_smi_o (slave_smi),
        .wake_o      (wake)
    );

    // R4
    alert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_sts[ALERT_IDX]) |-> ($past(alert_n, SYNC_STAGES) == 1'b0))
        else $error("alert status without a low pin");

    // R7
    slv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_smi_sts) |-> $past((slv_wake_cmd && !sys_asleep) || (slv_link_cmd && sys_full_on)))
        else $error("slave SMI status without a cause");

endmodule

// File: tb/smb_evt_router_bench.sv
`timescale 1ns/1ps
module smb_evt_router_bench;

    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] host_evt = '0;
    logic          alert_n = 1'b1;
    logic          slv_wake_cmd = 1'b0;
    logic          slv_link_cmd = 1'b0;
    logic          notify_evt = 1'b0;
    logic          cfg_int_en = 1'b0;
    logic          cfg_smi_sel = 1'b0;
    logic          cfg_alert_dis = 1'b0;
    logic          cfg_ntfy_int_en = 1'b0;
    logic          cfg_ntfy_wake_en = 1'b0;
    logic          sys_asleep = 1'b0;
    logic          sys_full_on = 1'b1;
    logic [HW:0]   host_clr = '0;
    logic          slv_smi_clr = 1'b0;
    logic          notify_clr = 1'b0;
    logic [HW:0]   host_sts;
    logic          slv_smi_sts;
    logic          notify_sts;
    logic          irq;
    logic          host_smi;
    logic          slave_smi;
    logic          wake;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    smb_evt_router u_smb_evt_router (
        .clk(clk), .rst_n(rst_n), .host_evt(host_evt), .alert_n(alert_n),
        .slv_wake_cmd(slv_wake_cmd), .slv_link_cmd(slv_link_cmd), .notify_evt(notify_evt),
        .cfg_int_en(cfg_int_en), .cfg_smi_sel(cfg_smi_sel), .cfg_alert_dis(cfg_alert_dis),
        .cfg_ntfy_int_en(cfg_ntfy_int_en), .cfg_ntfy_wake_en(cfg_ntfy_wake_en),
        .sys_asleep(sys_asleep), .sys_full_on(sys_full_on), .host_clr(host_clr),
        .slv_smi_clr(slv_smi_clr), .notify_clr(notify_clr), .host_sts(host_sts),
        .slv_smi_sts(slv_smi_sts), .notify_sts(notify_sts), .irq(irq),
        .host_smi(host_smi), .slave_smi(slave_smi), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        host_clr = '1; slv_smi_clr = 1'b1; notify_clr = 1'b1;
        step();
        host_clr = '0; slv_smi_clr = 1'b0; notify_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 host_sts", 32'(host_sts), 0);
        chk("R12 slave/notify sts", {30'd0, slv_smi_sts, notify_sts}, 0);
        chk("R12 outputs", {28'd0, irq, host_smi, slave_smi, wake}, 0);
    endtask

    task automatic t_host_irq();
        cfg_int_en = 1'b1; cfg_smi_sel = 1'b0;
        host_evt = 4'b0100; step(); host_evt = '0;
        chk("R1 host bit set", 32'(host_sts), 32'h04);
        chk("R2 irq", {31'd0, irq}, 1);
        chk("R3 no host smi", {31'd0, host_smi}, 0);
        host_clr = 5'b00001; step(); host_clr = '0;
        chk("R1 other clear keeps bit", 32'(host_sts), 32'h04);
        host_clr = 5'b00100; step(); host_clr = '0;
        chk("R1 clear", 32'(host_sts), 0);
        chk("R2 irq drops", {31'd0, irq}, 0);
        host_evt = 4'b0010; host_clr = 5'b00010; step(); host_evt = '0; host_clr = '0;
        chk("R1 set beats clear", 32'(host_sts), 32'h02);
        clear_all();
    endtask

    task automatic t_host_smi();
        cfg_int_en = 1'b1; cfg_smi_sel = 1'b1;
        host_evt = 4'b1000; step(); host_evt = '0;
        chk("R3 host smi", {31'd0, host_smi}, 1);
        chk("R3 irq low under smi", {31'd0, irq}, 0);
        cfg_int_en = 1'b0; step();
        chk("R3 int_en 0 no smi/irq", {30'd0, host_smi, irq}, 0);
        chk("R3 status kept", 32'(host_sts), 32'h08);
        cfg_smi_sel = 1'b0; step();
        chk("R3 int_en 0 no irq", {31'd0, irq}, 0);
        clear_all();
    endtask

    task automatic t_alert();
        cfg_int_en = 1'b1; cfg_smi_sel = 1'b0; cfg_alert_dis = 1'b0; sys_asleep = 1'b1;
        alert_n = 1'b0;
        step(); step();
        chk("R4 no status before third edge", 32'(host_sts[HW]), 0);
        step();
        chk("R4 alert status", 32'(host_sts[HW]), 1);
        chk("R5 alert irq", {31'd0, irq}, 1);
        chk("R5 alert wake", {31'd0, wake}, 1);
        step();
        chk("R10 wake one cycle", {31'd0, wake}, 0);
        host_clr = 5'b10000; step(); host_clr = '0;
        step(); step();
        chk("R4 held low sets once", 32'(host_sts[HW]), 0);
        alert_n = 1'b1; step(); step(); step();
        cfg_alert_dis = 1'b1; alert_n = 1'b0;
        step(); step(); step();
        chk("R5 disabled alert recorded", 32'(host_sts[HW]), 1);
        chk("R5 disabled alert silent", {29'd0, irq, slave_smi, wake}, 0);
        alert_n = 1'b1; cfg_alert_dis = 1'b0; step();
        chk("R5 enabled alert irq", {31'd0, irq}, 1);
        cfg_smi_sel = 1'b1; step();
        chk("R5 alert to slave smi", {30'd0, slave_smi, irq}, 2);
        cfg_smi_sel = 1'b0; sys_asleep = 1'b0;
        step(); step();
        clear_all();
    endtask

    task automatic t_slave_cmd();
        cfg_int_en = 1'b0;
        sys_asleep = 1'b1; slv_wake_cmd = 1'b1; step(); slv_wake_cmd = 1'b0;
        chk("R6 asleep wake", {31'd0, wake}, 1);
        chk("R6 asleep no slave sts", {31'd0, slv_smi_sts}, 0);
        step();
        chk("R10 wake cleared", {31'd0, wake}, 0);
        sys_asleep = 1'b0; slv_wake_cmd = 1'b1; step(); slv_wake_cmd = 1'b0;
        chk("R6 awake slave sts and smi", {29'd0, slv_smi_sts, slave_smi, wake}, 6);
        slv_smi_clr = 1'b1; step(); slv_smi_clr = 1'b0;
        chk("R6 slave smi clears", {30'd0, slv_smi_sts, slave_smi}, 0);
        sys_full_on = 1'b0; slv_link_cmd = 1'b1; step(); slv_link_cmd = 1'b0;
        chk("R7 link ignored when not full on", {30'd0, slv_smi_sts, slave_smi}, 0);
        sys_full_on = 1'b1; slv_link_cmd = 1'b1; step(); slv_link_cmd = 1'b0;
        chk("R7 link sets slave sts", {30'd0, slv_smi_sts, slave_smi}, 3);
        clear_all();
    endtask

    task automatic t_notify();
        cfg_ntfy_int_en = 1'b0; cfg_ntfy_wake_en = 1'b0; sys_asleep = 1'b1;
        notify_evt = 1'b1; step(); notify_evt = 1'b0;
        chk("R8 notify status", {31'd0, notify_sts}, 1);
        chk("R9 both enables 0 silent", {29'd0, irq, slave_smi, wake}, 0);
        clear_all();
        cfg_ntfy_wake_en = 1'b1;
        notify_evt = 1'b1; step(); notify_evt = 1'b0;
        chk("R8 notify wake", {31'd0, wake}, 1);
        clear_all();
        sys_asleep = 1'b0;
        notify_evt = 1'b1; step(); notify_evt = 1'b0;
        chk("R10 no wake when awake", {31'd0, wake}, 0);
        clear_all();
        cfg_ntfy_wake_en = 1'b0; cfg_ntfy_int_en = 1'b1; cfg_smi_sel = 1'b0;
        notify_evt = 1'b1; step(); notify_evt = 1'b0;
        chk("R9 notify irq", {30'd0, irq, slave_smi}, 2);
        cfg_smi_sel = 1'b1; step();
        chk("R9 notify slave smi", {30'd0, irq, slave_smi}, 1);
        cfg_smi_sel = 1'b0;
        clear_all();
    endtask

    task automatic t_additive();
        cfg_ntfy_int_en = 1'b1; cfg_ntfy_wake_en = 1'b1; cfg_smi_sel = 1'b0; sys_asleep = 1'b1;
        notify_evt = 1'b1; step(); notify_evt = 1'b0;
        chk("R11 wake and irq together", {30'd0, wake, irq}, 3);
        sys_asleep = 1'b0; cfg_ntfy_int_en = 1'b0; cfg_ntfy_wake_en = 1'b0;
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_host_irq();
        t_host_smi();
        t_alert();
        t_slave_cmd();
        t_notify();
        t_additive();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule